// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block holds the base mode register of a DDR memory device and turns a burst request into the column addresses for that burst, one address per clock. A load-mode command carries a two-bit bank select and a 13-bit address word. Only a load with bank select 00 writes the stored register. The stored word is decoded into a burst length of 2, 4 or 8, a burst order (sequential or interleaved), a CAS latency of 2 or 2.5, and an operating mode (normal, or normal with a DLL reset request). Any reserved encoding in the length, latency or operating-mode field raises an invalid-mode flag. No burst can start while that flag is high.

When a burst is accepted, the column bits above the burst's low bits stay fixed and select an aligned block. The low bits start at the requested column and run through the block in the chosen order, wrapping at the block boundary. A new burst may be requested on the last beat of the current one, so bursts can follow each other with no gap. A load command that arrives while a burst is in progress is refused and reported on an error pulse.

Top module: `ddr_burst_seq`

## Requirements
- R1: After reset the stored mode word is zero. Therefore `mode_invalid` is 1, and `col_valid`, `col_last`, `load_err`, `dec_bl`, `dec_ilv`, `dec_cl_x2` and `dec_dll_rst` are all 0.
- R2: Address bits [2:0] of the stored word give the burst length. 001 decodes to `dec_bl`=2, 010 to 4 and 011 to 8. Every other code gives `dec_bl`=0 and sets `mode_invalid`.
- R3: Address bit [3] of the stored word gives the burst order on `dec_ilv`: 0 is sequential and 1 is interleaved.
- R4: Address bits [6:4] of the stored word give the CAS latency, reported in half cycles on `dec_cl_x2`. 010 gives 4 (latency 2) and 110 gives 5 (latency 2.5). Every other code gives 0 and sets `mode_invalid`.
- R5: Address bits [12:7] of the stored word give the operating mode. 000000 is normal operation. 000010 (only address bit 8 set) is normal operation with a DLL reset, and sets `dec_dll_rst`. Every other value sets `mode_invalid`.
- R6: A load command writes the stored word, taking effect one clock later, only when `lmr_bank` is 00. Bank select 01, 10 or 11 leaves every decoded output unchanged.
- R7: While `mode_invalid` is 1, a `burst_start` pulse produces no beats.
- R8: An accepted start produces its first address on the clock after the start. Each following clock produces the next address, with `col_valid` high for exactly BL consecutive cycles. `col_last` is high on the final beat only.
- R9: In sequential order, beat k carries the start column with its low log2(BL) bits replaced by (start + k) mod BL. The upper bits stay fixed; for example, start 5 with BL 8 gives 5,6,7,0,1,2,3,4.
- R10: In interleaved order, beat k carries the start column with its low log2(BL) bits replaced by (start XOR k). For example, start 6 with BL 8 gives 6,7,4,5,2,3,0,1.
- R11: A load command, with any bank select, in a cycle where a beat is being output (including the last beat) is discarded. `load_err` is then high for exactly the following cycle.
- R12: A start that arrives during a burst but not on its last beat is ignored. A start on the last beat is accepted, and its first address follows in the very next cycle.
- R13: A load and a start in the same idle cycle are both accepted. The burst uses the mode that was stored before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lmr_valid | input | 1 | Load-mode command strobe |
| lmr_bank | input | 2 | Bank select of the load command |
| lmr_addr | input | AW | Address word of the load command |
| burst_start | input | 1 | Burst request pulse |
| start_col | input | COL_W | Starting column of the requested burst |
| col_out | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is present on `col_out` |
| col_last | output | 1 | Final beat of the burst |
| mode_invalid | output | 1 | Stored word holds a reserved encoding |
| load_err | output | 1 | Load was refused during a burst |
| dec_bl | output | 4 | Decoded burst length (0 if reserved) |
| dec_ilv | output | 1 | Interleaved order selected |
| dec_cl_x2 | output | 3 | CAS latency in half cycles (0 if reserved) |
| dec_dll_rst | output | 1 | Operating mode requests a DLL reset |

## Verification
Two events can fall in the same cycle: a mode-register load and the start or running of a burst. The bench provokes a load on a middle beat and on the last beat of a burst. It checks that `load_err` pulses for one cycle and that the decoded fields keep their old values. It also drives a load and a start together in an idle cycle. There it judges that the burst follows the old mode beat by beat while the decoded outputs already show the new one. A second collision, a start on the last beat against a start on a middle beat, is checked for seamless continuation and for no effect, respectively.

// File: rtl/ddr_burst_seq.sv
module ddr_burst_seq #(
  parameter int COL_W = 10,
  parameter int AW    = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lmr_valid,
  input  logic [1:0]       lmr_bank,
  input  logic [AW-1:0]    lmr_addr,
  input  logic             burst_start,
  input  logic [COL_W-1:0] start_col,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             col_last,
  output logic             mode_invalid,
  output logic             load_err,
  output logic [3:0]       dec_bl,
  output logic             dec_ilv,
  output logic [2:0]       dec_cl_x2,
  output logic             dec_dll_rst
);

  localparam int MW = 13;

  logic [MW-1:0] mode_q;
  logic [2:0]    bl_f, cl_f;
  logic [5:0]    op_f;
  logic          bl_ok, op_ok;

  assign bl_f = mode_q[2:0];
  assign cl_f = mode_q[6:4];
  assign op_f = mode_q[12:7];

  assign bl_ok       = (bl_f == 3'd1) || (bl_f == 3'd2) || (bl_f == 3'd3);
  assign dec_bl      = bl_ok ? 4'(4'd1 << bl_f) : 4'd0;
  assign dec_ilv     = mode_q[3];
  assign dec_cl_x2   = (cl_f == 3'b010) ? 3'd4 : (cl_f == 3'b110) ? 3'd5 : 3'd0;
  assign op_ok       = (op_f == 6'b000000) || (op_f == 6'b000010);
  assign dec_dll_rst = (op_f == 6'b000010);
  assign mode_invalid = !bl_ok || (dec_cl_x2 == 3'd0) || !op_ok;

  logic             busy, ilv_q;
  logic [1:0]       lcode;
  logic [2:0]       cnt, mask, low;
  logic [COL_W-1:0] col_q;
  logic             accept;

  assign mask     = 3'((4'd1 << lcode) - 4'd1);
  assign low      = ilv_q ? ((col_q[2:0] ^ cnt) & mask) : (3'(col_q[2:0] + cnt) & mask);
  assign col_out  = {col_q[COL_W-1:3], (col_q[2:0] & ~mask) | low};
  assign col_valid = busy;
  assign col_last  = busy && (cnt == mask);
  assign accept    = burst_start && !mode_invalid && (!busy || col_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      lcode <= 2'd1;
      ilv_q <= 1'b0;
      col_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      cnt   <= '0;
      lcode <= bl_f[1:0];
      ilv_q <= mode_q[3];
      col_q <= start_col;
    end else if (col_last) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      load_err <= 1'b0;
    end else begin
      load_err <= lmr_valid && busy;
      if (lmr_valid && (lmr_bank == 2'b00) && !busy)
        mode_q <= lmr_addr[MW-1:0];
    end
  end

  p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_err |-> $past(lmr_valid && col_valid));

  p_mode_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |=> $stable(mode_q));

  p_other_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lmr_valid && lmr_bank != 2'b00) |=> $stable(mode_q));

  p_no_start_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && mode_invalid && !col_valid) |=> !col_valid);

  p_block_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !col_last) |=> (col_valid && col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

  p_last_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  p_gap_after_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !burst_start) |=> !col_valid);

endmodule

// File: tb/test_ddr_burst_seq.sv
module test_ddr_burst_seq;
  localparam int COL_W = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lmr_valid = 1'b0, burst_start = 1'b0;
  logic [1:0] lmr_bank = 2'b00;
  logic [12:0] lmr_addr = '0;
  logic [COL_W-1:0] start_col = '0;
  logic [COL_W-1:0] col_out;
  logic col_valid, col_last, mode_invalid, load_err, dec_ilv, dec_dll_rst;
  logic [3:0] dec_bl;
  logic [2:0] dec_cl_x2;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  ddr_burst_seq #(.COL_W(COL_W), .AW(13)) i_ddr_burst_seq (
    .clk(clk), .rst_n(rst_n), .lmr_valid(lmr_valid), .lmr_bank(lmr_bank),
    .lmr_addr(lmr_addr), .burst_start(burst_start), .start_col(start_col),
    .col_out(col_out), .col_valid(col_valid), .col_last(col_last),
    .mode_invalid(mode_invalid), .load_err(load_err), .dec_bl(dec_bl),
    .dec_ilv(dec_ilv), .dec_cl_x2(dec_cl_x2), .dec_dll_rst(dec_dll_rst));

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int k, int bl, bit ilv);
    int m = bl - 1;
    int lo = ilv ? ((s ^ k) & m) : ((s + k) & m);
    return (s & ~m) | lo;
  endfunction

  function automatic logic [12:0] mword(int blc, bit ilv, int clc, int op);
    return {6'(op), 3'(clc), ilv, 3'(blc)};
  endfunction

  task automatic lmr(logic [1:0] bank, logic [12:0] a);
    lmr_valid = 1'b1; lmr_bank = bank; lmr_addr = a;
    @(negedge clk);
    lmr_valid = 1'b0; lmr_bank = 2'b00;
  endtask

  task automatic beat(string tag, int s, int k, int bl, bit ilv);
    chk({tag, " valid"}, col_valid, 1);
    chk({tag, " col"}, col_out, exp_col(s, k, bl, ilv));
    chk({tag, " last"}, col_last, (k == bl - 1));
  endtask

  task automatic burst(string tag, int s, int bl, bit ilv);
    burst_start = 1'b1; start_col = COL_W'(s);
    @(negedge clk);
    burst_start = 1'b0;
    for (int k = 0; k < bl; k++) begin
      beat(tag, s, k, bl, ilv);
      @(negedge clk);
    end
    chk({tag, " idle after"}, col_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 invalid", mode_invalid, 1);
    chk("R1 valid", col_valid, 0);
    chk("R1 err", load_err, 0);
    chk("R1 bl", dec_bl, 0);
    chk("R1 cl", dec_cl_x2, 0);
    chk("R1 ilv", dec_ilv, 0);
    chk("R1 dll", dec_dll_rst, 0);

    // R7 start refused while invalid
    burst_start = 1'b1; start_col = 10'd3;
    @(negedge clk);
    burst_start = 1'b0;
    chk("R7 no beat", col_valid, 0);
    @(negedge clk);
    chk("R7 no beat 2", col_valid, 0);

    // R2 burst length codes
    for (int c = 0; c < 8; c++) begin
      lmr(2'b00, mword(c, 0, 2, 0));
      chk("R2 bl", dec_bl, (c >= 1 && c <= 3) ? (1 << c) : 0);
      chk("R2 invalid", mode_invalid, !(c >= 1 && c <= 3));
    end
    // R4 latency codes
    for (int c = 0; c < 8; c++) begin
      lmr(2'b00, mword(2, 0, c, 0));
      chk("R4 cl", dec_cl_x2, (c == 2) ? 4 : (c == 6) ? 5 : 0);
      chk("R4 invalid", mode_invalid, !(c == 2 || c == 6));
    end
    // R5 operating modes
    lmr(2'b00, mword(2, 0, 2, 2));
    chk("R5 dll", dec_dll_rst, 1);
    chk("R5 valid dll", mode_invalid, 0);
    lmr(2'b00, mword(2, 0, 2, 1));
    chk("R5 reserved", mode_invalid, 1);
    lmr(2'b00, mword(2, 0, 2, 32));
    chk("R5 reserved high", mode_invalid, 1);
    lmr(2'b00, mword(2, 0, 2, 6));
    chk("R5 reserved two bits", mode_invalid, 1);
    // R3 order bit
    lmr(2'b00, mword(3, 1, 6, 0));
    chk("R3 ilv", dec_ilv, 1);
    chk("R5 dll off", dec_dll_rst, 0);

    // R6 other banks ignored
    for (int b = 1; b < 4; b++) begin
      lmr(2'(b), mword(1, 0, 2, 2));
      chk("R6 bl kept", dec_bl, 8);
      chk("R6 ilv kept", dec_ilv, 1);
      chk("R6 cl kept", dec_cl_x2, 5);
    end

    // R9, R10 directed
    lmr(2'b00, mword(3, 0, 2, 0));
    burst("R9 seq start5", 5, 8, 0);
    burst("R9 seq upper", 10'h3F6, 8, 0);
    lmr(2'b00, mword(3, 1, 2, 0));
    burst("R10 ilv start6", 6, 8, 1);
    lmr(2'b00, mword(2, 1, 2, 0));
    burst("R10 ilv bl4", 10'h2D3, 4, 1);
    lmr(2'b00, mword(1, 0, 6, 0));
    burst("R8 bl2", 10'h101, 2, 0);

    // R8-R10 random
    for (int i = 0; i < 60; i++) begin
      int blc = 1 + ($urandom % 3);
      bit il = 1'($urandom);
      int s = $urandom % (1 << COL_W);
      lmr(2'b00, mword(blc, il, ($urandom % 2) ? 2 : 6, ($urandom % 2) ? 0 : 2));
      burst(il ? "R10 rand" : "R9 rand", s, 1 << blc, il);
    end

    // R12 start mid-burst ignored, start on last beat chained
    lmr(2'b00, mword(2, 0, 2, 0));
    burst_start = 1'b1; start_col = 10'd9;
    @(negedge clk);
    beat("R12 a", 9, 0, 4, 0);
    start_col = 10'd100;
    @(negedge clk);
    beat("R12 ignored", 9, 1, 4, 0);
    burst_start = 1'b0;
    @(negedge clk);
    beat("R12 a", 9, 2, 4, 0);
    @(negedge clk);
    beat("R12 a last", 9, 3, 4, 0);
    burst_start = 1'b1; start_col = 10'd66;
    @(negedge clk);
    burst_start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      beat("R12 chained", 66, k, 4, 0);
      @(negedge clk);
    end
    chk("R12 idle", col_valid, 0);

    // R11 load during burst (middle and last beat)
    burst_start = 1'b1; start_col = 10'd20;
    @(negedge clk);
    burst_start = 1'b0;
    beat("R11 b", 20, 0, 4, 0);
    lmr(2'b00, mword(3, 1, 6, 0));
    beat("R11 b", 20, 1, 4, 0);
    chk("R11 err", load_err, 1);
    @(negedge clk);
    chk("R11 err clear", load_err, 0);
    beat("R11 b", 20, 2, 4, 0);
    @(negedge clk);
    beat("R11 b last", 20, 3, 4, 0);
    lmr(2'b01, mword(3, 1, 6, 0));
    chk("R11 err last", load_err, 1);
    chk("R11 bl kept", dec_bl, 4);
    chk("R11 ilv kept", dec_ilv, 0);
    @(negedge clk);
    chk("R11 err clear 2", load_err, 0);

    // R13 load and start together while idle
    lmr_valid = 1'b1; lmr_bank = 2'b00; lmr_addr = mword(1, 1, 6, 0);
    burst_start = 1'b1; start_col = 10'd45;
    @(negedge clk);
    lmr_valid = 1'b0; burst_start = 1'b0;
    chk("R13 new bl", dec_bl, 2);
    chk("R13 no err", load_err, 0);
    for (int k = 0; k < 4; k++) begin
      beat("R13 old mode", 45, k, 4, 0);
      @(negedge clk);
    end
    chk("R13 idle", col_valid, 0);
    burst("R13 new mode", 45, 2, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule